// File: doc/BRIEF.md
# Delayed-Branch Program Counter Sequencer

This block produces the instruction fetch address for a 32-bit RISC core in which every control transfer has one delay slot. It keeps three addresses: the current PC, the next PC and the previous PC. Each time an instruction retires, all three move forward together. When the execute stage reports a taken transfer, the new target is loaded into the next-PC slot rather than the current one. The instruction that already sits behind the transfer therefore still runs before control reaches the target.

The execute stage presents the transfer kind, a signed word offset, a register value and the compare flag with every retire. From these the block forms a PC-relative or register-indirect target and decides whether a conditional branch is taken. For calls it drives the link-register write. For a return from exception it reloads the PC from the saved exception address and asks for the saved status to be written back. An exception redirect overrides everything else in the same cycle and sends the current PC straight to the vector.

Top module: `pc_sequencer`

## Requirements
- R1: Once reset has been released, the current PC is 0x0, the next PC is 0x4, the previous PC is 0x0 and the delay-slot indicator is 0.
- R2: A retire with transfer code 0 (none) copies the current PC into the previous PC and the next PC into the current PC, and advances the next PC by 4. When neither retire nor exception is asserted, all three PCs hold their values.
- R3: The unconditional relative jump (code 3) takes the target as current PC plus the 26-bit sign-extended offset times 4. After that retire, the current PC is the old next PC (the delay slot), the next PC is the target and the delay-slot indicator is 1.
- R4: The branch on flag set (code 1) is taken only when the flag is 1. The branch on flag clear (code 2) is taken only when the flag is 0. An untaken branch behaves like code 0 and leaves the delay-slot indicator at 0.
- R5: The relative call (code 4) and the register call (code 6) raise the link write strobe in their retire cycle, with link data equal to the current PC plus 8. No other case raises the strobe.
- R6: The register jump (code 5) and the register call (code 6) use the full 32-bit register operand as the next PC, including its two low bits.
- R7: A return from exception (code 7) loads the saved exception PC into the current PC and that value plus 4 into the next PC, with no delay slot. In the same cycle it raises the status write strobe and presents the saved status word as the status data.
- R8: The fetch address equals the current PC with bits 1:0 forced to zero.
- R9: A transfer code presented while the delay-slot indicator is 1 is ignored. The sequence advances as with code 0 and neither the link strobe nor the status strobe is raised.
- R10: An exception redirect, with or without retire, loads the vector into the current PC and the vector plus 4 into the next PC. It clears the delay-slot indicator, overrides any transfer or pending delay target, and suppresses the link and status strobes in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| retire_i | input | 1 | The instruction at the current PC retires this cycle |
| op_i | input | 3 | Transfer code of the retiring instruction (0 none, 1 branch on flag, 2 branch on not flag, 3 jump, 4 call, 5 register jump, 6 register call, 7 return from exception) |
| flag_i | input | 1 | Compare flag |
| imm_i | input | 26 | Signed word offset for relative transfers |
| reg_i | input | 32 | Register operand for indirect transfers |
| epc_i | input | 32 | Saved exception PC |
| esr_i | input | 32 | Saved status word |
| exc_i | input | 1 | Exception redirect request |
| exc_vec_i | input | 32 | Exception vector address |
| pc_o | output | 32 | Current PC |
| npc_o | output | 32 | Next PC |
| ppc_o | output | 32 | Previous PC |
| fetch_addr_o | output | 32 | Word-aligned fetch address |
| in_delay_o | output | 1 | Current instruction is in a delay slot |
| link_we_o | output | 1 | Link register write strobe |
| link_data_o | output | 32 | Link register write value |
| sr_we_o | output | 1 | Status register write strobe |
| sr_data_o | output | 32 | Status register write value |

## Verification
Two situations can land in the same cycle. In the first, an exception redirect arrives together with a retiring jump or call. In the second, an exception arrives while the delay slot of a taken transfer is retiring, which is the moment a pending target would otherwise be installed. The bench creates both on purpose: it asserts the exception in the retire cycle of a call, and again in the cycle after a taken jump. It then checks that the vector wins, that the link strobe stays low, and that the abandoned target never shows up in the next PC.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;
  typedef enum logic [2:0] {
    XF_NONE = 3'd0,
    XF_BF   = 3'd1,
    XF_BNF  = 3'd2,
    XF_J    = 3'd3,
    XF_JL   = 3'd4,
    XF_JR   = 3'd5,
    XF_JRL  = 3'd6,
    XF_RFE  = 3'd7
  } xfer_e;
endpackage

// File: rtl/pcseq_xfer.sv
module pcseq_xfer
  import pcseq_pkg::*;
#(
  parameter int AW       = 32,
  parameter int IMM_W    = 26,
  parameter int STEP     = 4,
  parameter int LINK_OFS = 8
) (
  input  logic [2:0]       op_i,
  input  logic             flag_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [AW-1:0]    reg_i,
  input  logic [AW-1:0]    pc_i,
  input  logic             slot_i,
  input  logic             retire_i,
  input  logic             exc_i,
  output logic             take_o,
  output logic [AW-1:0]    tgt_o,
  output logic             rfe_o,
  output logic             link_we_o,
  output logic [AW-1:0]    link_data_o
);
  localparam int SH  = $clog2(STEP);
  localparam int EXT = AW - IMM_W - SH;

  xfer_e         op;
  logic          live;
  logic          cond;
  logic [AW-1:0] rel;

  assign op   = xfer_e'(op_i);
  // Only a retiring, non-slot, non-excepting instruction may steer.
  assign live = retire_i & ~exc_i & ~slot_i;
  assign rel  = pc_i + {{EXT{imm_i[IMM_W-1]}}, imm_i, {SH{1'b0}}};

  always_comb begin
    cond  = 1'b0;
    tgt_o = rel;
    unique case (op)
      XF_BF:          cond = flag_i;
      XF_BNF:         cond = ~flag_i;
      XF_J, XF_JL:    cond = 1'b1;
      XF_JR, XF_JRL: begin
        cond  = 1'b1;
        tgt_o = reg_i;
      end
      default:        cond = 1'b0;
    endcase
  end

  assign take_o      = live & cond;
  assign rfe_o       = live & (op == XF_RFE);
  assign link_we_o   = live & ((op == XF_JL) | (op == XF_JRL));
  assign link_data_o = pc_i + AW'(LINK_OFS);
endmodule

// File: rtl/pcseq_state.sv
module pcseq_state #(
  parameter int          AW     = 32,
  parameter int          STEP   = 4,
  parameter logic [31:0] RST_PC = 32'h0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic          exc_i,
  input  logic [AW-1:0] vec_i,
  input  logic          rfe_i,
  input  logic [AW-1:0] epc_i,
  input  logic          take_i,
  input  logic [AW-1:0] tgt_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] npc_o,
  output logic [AW-1:0] ppc_o,
  output logic          slot_o
);
  localparam logic [AW-1:0] INC = AW'(STEP);
  localparam logic [AW-1:0] PC0 = AW'(RST_PC);

  logic [AW-1:0] pc_q, npc_q, ppc_q;
  logic [AW-1:0] pc_d, npc_d, ppc_d;
  logic          slot_q, slot_d;

  always_comb begin
    ppc_d = pc_q;
    if (exc_i) begin
      pc_d   = vec_i;
      npc_d  = vec_i + INC;
      slot_d = 1'b0;
    end else if (rfe_i) begin
      pc_d   = epc_i;
      npc_d  = epc_i + INC;
      slot_d = 1'b0;
    end else begin
      pc_d   = npc_q;
      npc_d  = take_i ? tgt_i : npc_q + INC;
      slot_d = take_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= PC0;
      npc_q  <= PC0 + INC;
      ppc_q  <= PC0;
      slot_q <= 1'b0;
    end else if (adv_i) begin
      pc_q   <= pc_d;
      npc_q  <= npc_d;
      ppc_q  <= ppc_d;
      slot_q <= slot_d;
    end
  end

  assign pc_o   = pc_q;
  assign npc_o  = npc_q;
  assign ppc_o  = ppc_q;
  assign slot_o = slot_q;
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int          AW       = 32,
  parameter int          IMM_W    = 26,
  parameter int          STEP     = 4,
  parameter int          LINK_OFS = 8,
  parameter logic [31:0] RST_PC   = 32'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire_i,
  input  logic [2:0]       op_i,
  input  logic             flag_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [AW-1:0]    reg_i,
  input  logic [AW-1:0]    epc_i,
  input  logic [AW-1:0]    esr_i,
  input  logic             exc_i,
  input  logic [AW-1:0]    exc_vec_i,
  output logic [AW-1:0]    pc_o,
  output logic [AW-1:0]    npc_o,
  output logic [AW-1:0]    ppc_o,
  output logic [AW-1:0]    fetch_addr_o,
  output logic             in_delay_o,
  output logic             link_we_o,
  output logic [AW-1:0]    link_data_o,
  output logic             sr_we_o,
  output logic [AW-1:0]    sr_data_o
);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'(STEP - 1);

  logic [1:0]    rs_q;
  logic          rst_int_n;
  logic          take, rfe, slot;
  logic [AW-1:0] tgt;

  // Reset asserts asynchronously, releases on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  pcseq_xfer #(.AW(AW), .IMM_W(IMM_W), .STEP(STEP), .LINK_OFS(LINK_OFS)) u_xfer (
    .op_i        (op_i),
    .flag_i      (flag_i),
    .imm_i       (imm_i),
    .reg_i       (reg_i),
    .pc_i        (pc_o),
    .slot_i      (slot),
    .retire_i    (retire_i),
    .exc_i       (exc_i),
    .take_o      (take),
    .tgt_o       (tgt),
    .rfe_o       (rfe),
    .link_we_o   (link_we_o),
    .link_data_o (link_data_o)
  );

  pcseq_state #(.AW(AW), .STEP(STEP), .RST_PC(RST_PC)) u_state (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .adv_i  (retire_i | exc_i),
    .exc_i  (exc_i),
    .vec_i  (exc_vec_i),
    .rfe_i  (rfe),
    .epc_i  (epc_i),
    .take_i (take),
    .tgt_i  (tgt),
    .pc_o   (pc_o),
    .npc_o  (npc_o),
    .ppc_o  (ppc_o),
    .slot_o (slot)
  );

  assign fetch_addr_o = pc_o & ALIGN_MASK;
  assign in_delay_o   = slot;
  assign sr_we_o      = rfe;
  assign sr_data_o    = esr_i;
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk
  import pcseq_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          retire_i,
  input logic [2:0]    op_i,
  input logic          exc_i,
  input logic [AW-1:0] exc_vec_i,
  input logic [AW-1:0] pc_o,
  input logic [AW-1:0] npc_o,
  input logic [AW-1:0] ppc_o,
  input logic          in_delay_o,
  input logic          link_we_o,
  input logic          sr_we_o
);
  logic jumpy;
  assign jumpy = (op_i == XF_J) || (op_i == XF_JL) || (op_i == XF_JR) || (op_i == XF_JRL);

  // R2: an advance records the old current PC as previous
  p_prev_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && !exc_i) |=> (ppc_o == $past(pc_o)));

  // R2: idle cycles leave the PCs untouched
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire_i && !exc_i) |=> ($stable(pc_o) && $stable(npc_o) && $stable(ppc_o)));

  // R3: an unconditional transfer outside a slot opens a delay slot at the old next PC
  p_slot_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && !exc_i && !in_delay_o && jumpy) |=> (in_delay_o && pc_o == $past(npc_o)));

  // R9: a delay slot never opens another one
  p_no_nest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && !exc_i && in_delay_o) |=> !in_delay_o);

  // R9: no side strobes from a slot instruction
  p_slot_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_delay_o |-> (!link_we_o && !sr_we_o));

  // R10: the vector wins and the slot is dropped
  p_exc_redirect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exc_i |=> (pc_o == $past(exc_vec_i) && !in_delay_o));
endmodule

bind pc_sequencer pc_sequencer_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .retire_i   (retire_i),
  .op_i       (op_i),
  .exc_i      (exc_i),
  .exc_vec_i  (exc_vec_i),
  .pc_o       (pc_o),
  .npc_o      (npc_o),
  .ppc_o      (ppc_o),
  .in_delay_o (in_delay_o),
  .link_we_o  (link_we_o),
  .sr_we_o    (sr_we_o)
);

// File: tb/pc_sequencer_tb.sv
`timescale 1ns/1ps
module pc_sequencer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        retire_i, flag_i, exc_i;
  logic [2:0]  op_i;
  logic [25:0] imm_i;
  logic [31:0] reg_i, epc_i, esr_i, exc_vec_i;
  logic [31:0] pc_o, npc_o, ppc_o, fetch_addr_o, link_data_o, sr_data_o;
  logic        in_delay_o, link_we_o, sr_we_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_pc, m_npc, m_ppc;
  bit          m_dly;

  always #5 clk = ~clk;

  pc_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .op_i(op_i), .flag_i(flag_i),
    .imm_i(imm_i), .reg_i(reg_i), .epc_i(epc_i), .esr_i(esr_i), .exc_i(exc_i),
    .exc_vec_i(exc_vec_i), .pc_o(pc_o), .npc_o(npc_o), .ppc_o(ppc_o),
    .fetch_addr_o(fetch_addr_o), .in_delay_o(in_delay_o), .link_we_o(link_we_o),
    .link_data_o(link_data_o), .sr_we_o(sr_we_o), .sr_data_o(sr_data_o)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit ret, logic [2:0] op, bit flg,
                      logic [25:0] imm, logic [31:0] rv, bit ex, logic [31:0] vec);
    bit          live, take, e_link, e_sr;
    int          off;
    logic [2:0]  eff;
    logic [31:0] tgt;
    @(negedge clk);
    retire_i = ret; op_i = op; flag_i = flg; imm_i = imm; reg_i = rv;
    exc_i = ex; exc_vec_i = vec;
    #1;
    live   = ret && !ex && !m_dly;
    eff    = live ? op : 3'd0;
    e_link = live && (op == 3'd4 || op == 3'd6);
    e_sr   = live && (op == 3'd7);
    chk(tag, "pc", pc_o, m_pc);
    chk(tag, "npc", npc_o, m_npc);
    chk(tag, "ppc", ppc_o, m_ppc);
    chk(tag, "in_delay", {31'd0, in_delay_o}, {31'd0, m_dly});
    chk("R8", "fetch_addr", fetch_addr_o, {m_pc[31:2], 2'b00});
    chk(tag, "link_we", {31'd0, link_we_o}, {31'd0, e_link});
    if (e_link) chk("R5", "link_data", link_data_o, m_pc + 32'd8);
    chk(tag, "sr_we", {31'd0, sr_we_o}, {31'd0, e_sr});
    if (e_sr) chk("R7", "sr_data", sr_data_o, esr_i);
    @(posedge clk);
    off  = imm[25] ? int'(imm) - (1 << 26) : int'(imm);
    take = 0;
    tgt  = m_pc + 32'(off * 4);
    case (eff)
      3'd1: take = flg;
      3'd2: take = !flg;
      3'd3, 3'd4: take = 1;
      3'd5, 3'd6: begin take = 1; tgt = rv; end
      default: take = 0;
    endcase
    if (ex) begin
      m_ppc = m_pc; m_pc = vec; m_npc = vec + 32'd4; m_dly = 0;
    end else if (ret) begin
      m_ppc = m_pc;
      if (eff == 3'd7) begin
        m_pc = epc_i; m_npc = epc_i + 32'd4; m_dly = 0;
      end else begin
        m_pc = m_npc; m_npc = take ? tgt : m_npc + 32'd4; m_dly = take;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; retire_i = 0; op_i = 0; flag_i = 0; imm_i = 0; reg_i = 0;
    exc_i = 0; exc_vec_i = 0; epc_i = 32'h0000_2000; esr_i = 32'h0000_1234;
    m_pc = 32'h0; m_npc = 32'h4; m_ppc = 32'h0; m_dly = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    step("R1", 0, 3'd0, 0, 26'd0, 32'd0, 0, 32'd0);
    // R2 straight-line flow and hold
    step("R2", 1, 3'd0, 0, 26'd0, 32'd0, 0, 32'd0);
    step("R2", 1, 3'd0, 0, 26'd0, 32'd0, 0, 32'd0);
    step("R2", 0, 3'd0, 0, 26'd0, 32'd0, 0, 32'd0);
    step("R2", 1, 3'd0, 0, 26'd0, 32'd0, 0, 32'd0);
    // R3 forward and backward relative jumps with their slots
    step("R3", 1, 3'd3, 0, 26'd5, 32'd0, 0, 32'd0);
    step("R3", 1, 3'd0, 0, 26'd0, 32'd0, 0, 32'd0);
    step("R3", 1, 3'd3, 0, 26'h3FF_FFFE, 32'd0, 0, 32'd0);
    step("R3", 1, 3'd0, 0, 26'd0, 32'd0, 0, 32'd0);
    step("R3", 1, 3'd0, 0, 26'd0, 32'd0, 0, 32'd0);
    // R4 conditional branches, both polarities
    step("R4", 1, 3'd1, 0, 26'd8, 32'd0, 0, 32'd0);
    step("R4", 1, 3'd1, 1, 26'd8, 32'd0, 0, 32'd0);
    step("R4", 1, 3'd0, 0, 26'd0, 32'd0, 0, 32'd0);
    step("R4", 1, 3'd2, 1, 26'd3, 32'd0, 0, 32'd0);
    step("R4", 1, 3'd2, 0, 26'd3, 32'd0, 0, 32'd0);
    step("R4", 1, 3'd0, 0, 26'd0, 32'd0, 0, 32'd0);
    // R5 relative call, R6 register call with unaligned target
    step("R5", 1, 3'd4, 0, 26'd16, 32'd0, 0, 32'd0);
    step("R5", 1, 3'd0, 0, 26'd0, 32'd0, 0, 32'd0);
    step("R6", 1, 3'd6, 0, 26'd0, 32'h0000_1002, 0, 32'd0);
    step("R6", 1, 3'd0, 0, 26'd0, 32'd0, 0, 32'd0);
    step("R8", 1, 3'd5, 0, 26'd0, 32'h0000_4444, 0, 32'd0);
    step("R6", 1, 3'd0, 0, 26'd0, 32'd0, 0, 32'd0);
    // R7 return from exception
    step("R7", 1, 3'd7, 0, 26'd0, 32'd0, 0, 32'd0);
    step("R7", 1, 3'd0, 0, 26'd0, 32'd0, 0, 32'd0);
    // R9 transfers inside a slot are dropped
    step("R9", 1, 3'd3, 0, 26'd40, 32'd0, 0, 32'd0);
    step("R9", 1, 3'd4, 0, 26'd9, 32'd0, 0, 32'd0);
    step("R9", 1, 3'd3, 0, 26'd2, 32'd0, 0, 32'd0);
    step("R9", 1, 3'd7, 0, 26'd0, 32'd0, 0, 32'd0);
    step("R9", 1, 3'd0, 0, 26'd0, 32'd0, 0, 32'd0);
    // R10 exception with a call, in a slot, and without retire
    step("R10", 1, 3'd4, 0, 26'd7, 32'd0, 1, 32'h0000_0700);
    step("R10", 1, 3'd3, 0, 26'd20, 32'd0, 0, 32'd0);
    step("R10", 1, 3'd0, 0, 26'd0, 32'd0, 1, 32'h0000_0E00);
    step("R10", 0, 3'd6, 0, 26'd0, 32'h0000_9000, 1, 32'h0000_0100);
    step("R10", 1, 3'd0, 0, 26'd0, 32'd0, 0, 32'd0);
    step("R2", 0, 3'd0, 0, 26'd0, 32'd0, 0, 32'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule